// File: doc/BRIEF.md
# Quad-lane flash read-through window

This block lets a simple word-read port fetch data from a serial NOR flash as if it were on-chip memory. When the requester asks for a word, the block runs a quad I/O fast-read transfer on the flash pins. The opcode goes out on one lane. Address, mode byte and data use all four lanes. The block assembles four consecutive flash bytes into a little-endian 32-bit word.

Once a transfer is open, chip select stays low and the block keeps clocking bytes into a small byte FIFO. A request for the next word is therefore answered without a new transfer. The mode byte puts the flash into continuous-read mode, so only the first transfer after enabling the window carries the opcode. Later transfers start directly at the address.

A request for any other word, or an idle timeout, closes the open transfer. A leave request closes it as well, then runs one single-byte read whose mode byte takes the flash out of continuous-read mode. After that the window is off until it is enabled again.

Top module: `qmap_reader`

## Requirements
- R1: After reset the flash chip select is high, the flash clock is low, no flash lane is driven, `bus_ready` is low and `mapped` is low.
- R2: While the window is off, a held request gets no `bus_ready` and causes no flash activity (chip select stays high).
- R3: The first transfer after `map_on` sends opcode 0xEB on lane 0 only, MSB first, over 8 clocks. It then sends the 24-bit byte address on all four lanes, most significant nibble first, over 6 clocks.
- R4: After the address, the mode byte 0xA0 goes out on four lanes in 2 clocks, high nibble first. Exactly 4 dummy clocks with all lanes released follow. Data is then read high nibble first, two clocks per byte.
- R5: Every later transfer while the window stays on omits the opcode and begins with the address phase.
- R6: `bus_rdata` carries the flash byte at address 4·`bus_waddr` in bits [7:0] and the following three bytes in ascending order above it. It is valid while `bus_ready` is high for one cycle.
- R7: After a read, chip select stays low. A request for the next word is served from the same transfer without a new chip-select fall.
- R8: Prefetch stops with exactly FIFO_DEPTH unread bytes buffered. The flash clock is then held low, with chip select low and `busy` high, until space frees.
- R9: A request for a word other than the next sequential one ends the open transfer. Chip select then stays high for at least CSH_CYC cycles, and a new transfer starts at the requested address.
- R10: With no request for TO_CYC cycles during an open transfer, chip select is released and `busy` falls once the deselect time has passed. A later request starts a new transfer without the opcode.
- R11: On `map_off`, `mapped` falls and any open transfer is ended. One transfer follows with opcode 0xEB, address 0, mode byte 0x5F, 4 dummy clocks and a single data byte, after which the window is off.
- R12: `busy` is high whenever chip select is low. The flash clock only toggles while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the flash clock runs at half its rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| map_on | input | 1 | One-cycle pulse that enables the read window |
| map_off | input | 1 | One-cycle pulse that leaves the window and ends continuous-read mode |
| bus_req | input | 1 | Read request, held until `bus_ready` |
| bus_waddr | input | 22 | Word address of the request |
| bus_rdata | output | 32 | Little-endian read data |
| bus_ready | output | 1 | One-cycle pulse: `bus_rdata` valid |
| mapped | output | 1 | Window is enabled and serving reads |
| busy | output | 1 | Flash selected or in its deselect time |
| fl_sclk | output | 1 | Flash serial clock |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_io_o | output | 4 | Flash lane output values |
| fl_io_oe | output | 4 | Flash lane output enables |
| fl_io_i | input | 4 | Flash lane input values |

## Verification
A wrong continuous-read bookkeeping bit shows up in the opcode count the flash sees on the very next transfer. An opcode is either missing after enable or present after a restart. A wrong phase length or dummy count misaligns every data nibble, so the first returned word of the affected transfer is wrong. FIFO pointer or count errors show up either as a wrong word on the next sequential hit or as a wrong number of prefetched bytes once the clock stalls. A missed abort appears as no new chip-select fall within a few cycles of a non-sequential request or of the timeout.

// File: rtl/qmap_pkg.sv
package qmap_pkg;
  localparam int FADDR_W = 24;
  localparam logic [7:0] OP_QREAD = 8'hEB;
  localparam logic [7:0] ALT_HOLD = 8'hA0;
  localparam logic [7:0] ALT_LEAVE = ~ALT_HOLD;
  localparam int DUMMY_N = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_ALT, PH_DUMMY, PH_DATA, PH_GAP
  } ph_t;

  typedef enum logic [2:0] {
    MS_OFF, MS_READY, MS_OPEN, MS_LEAVE, MS_FINAL
  } ms_t;
endpackage

// File: rtl/qmap_fifo.sv
module qmap_fifo #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [7:0]       push_byte,
  input  logic             pop4,
  output logic [31:0]      word,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = wr_q + PW'(1);
      if (pop4) rd_d = rd_q + PW'(4);
      cnt_d = cnt_q + (push ? CW'(1) : CW'(0)) - (pop4 ? CW'(4) : CW'(0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= push_byte;
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign word[8*k +: 8] = mem[rd_q + PW'(k)];
  end

  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/qmap_serial.sv
module qmap_serial
  import qmap_pkg::*;
#(
  parameter int CSH_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_cmd,
  input  logic [FADDR_W-1:0] start_addr,
  input  logic [7:0]         start_alt,
  input  logic               start_one,
  input  logic               abort,
  input  logic               hold,
  output logic               idle,
  output logic               byte_vld,
  output logic [7:0]         byte_out,
  output logic               sclk,
  output logic               cs_n,
  output logic [3:0]         io_o,
  output logic [3:0]         io_oe,
  input  logic [3:0]         io_i
);
  localparam int GW = $clog2(CSH_CYC + 1);

  ph_t         ph_q, ph_d;
  logic        half_q, half_d;
  logic [3:0]  cnt_q, cnt_d;
  logic [7:0]  cmd_q, cmd_d;
  logic [31:0] out_q, out_d;
  logic        one_q, one_d;
  logic [3:0]  hi_q, hi_d;
  logic        sclk_q, sclk_d;
  logic        cs_q, cs_d;
  logic [GW-1:0] gap_q, gap_d;

  always_comb begin
    ph_d = ph_q; half_d = half_q; cnt_d = cnt_q; cmd_d = cmd_q;
    out_d = out_q; one_d = one_q; hi_d = hi_q; sclk_d = sclk_q;
    cs_d = cs_q; gap_d = gap_q;
    if (ph_q == PH_IDLE) begin
      if (start) begin
        ph_d   = start_cmd ? PH_CMD : PH_ADDR;
        cs_d   = 1'b0;
        half_d = 1'b0;
        cnt_d  = '0;
        cmd_d  = OP_QREAD;
        out_d  = {start_addr, start_alt};
        one_d  = start_one;
      end
    end else if (ph_q == PH_GAP) begin
      if (gap_q == GW'(CSH_CYC - 1)) ph_d = PH_IDLE;
      else                           gap_d = gap_q + GW'(1);
    end else if (abort) begin
      ph_d   = PH_GAP;
      gap_d  = '0;
      cs_d   = 1'b1;
      sclk_d = 1'b0;
      half_d = 1'b0;
    end else if (!half_q) begin
      if (!(ph_q == PH_DATA && !cnt_q[0] && hold)) begin
        sclk_d = 1'b1;
        half_d = 1'b1;
        if (ph_q == PH_DATA && !cnt_q[0]) hi_d = io_i;
      end
    end else begin
      sclk_d = 1'b0;
      half_d = 1'b0;
      unique case (ph_q)
        PH_CMD: begin
          cmd_d = {cmd_q[6:0], 1'b0};
          if (cnt_q == 4'd7) begin ph_d = PH_ADDR; cnt_d = '0; end
          else cnt_d = cnt_q + 4'd1;
        end
        PH_ADDR: begin
          out_d = {out_q[27:0], 4'h0};
          if (cnt_q == 4'd5) begin ph_d = PH_ALT; cnt_d = '0; end
          else cnt_d = cnt_q + 4'd1;
        end
        PH_ALT: begin
          out_d = {out_q[27:0], 4'h0};
          if (cnt_q == 4'd1) begin ph_d = PH_DUMMY; cnt_d = '0; end
          else cnt_d = cnt_q + 4'd1;
        end
        PH_DUMMY: begin
          if (cnt_q == 4'(DUMMY_N - 1)) begin ph_d = PH_DATA; cnt_d = '0; end
          else cnt_d = cnt_q + 4'd1;
        end
        PH_DATA: begin
          cnt_d = {3'b000, ~cnt_q[0]};
          if (one_q && cnt_q[0]) begin
            ph_d  = PH_GAP;
            gap_d = '0;
            cs_d  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; half_q <= 1'b0; cnt_q <= '0; cmd_q <= '0;
      out_q <= '0; one_q <= 1'b0; hi_q <= '0; sclk_q <= 1'b0;
      cs_q <= 1'b1; gap_q <= '0;
    end else begin
      ph_q <= ph_d; half_q <= half_d; cnt_q <= cnt_d; cmd_q <= cmd_d;
      out_q <= out_d; one_q <= one_d; hi_q <= hi_d; sclk_q <= sclk_d;
      cs_q <= cs_d; gap_q <= gap_d;
    end
  end

  assign idle     = (ph_q == PH_IDLE);
  assign byte_vld = (ph_q == PH_DATA) && !half_q && cnt_q[0] && !abort;
  assign byte_out = {hi_q, io_i};
  assign sclk     = sclk_q;
  assign cs_n     = cs_q;
  assign io_o     = (ph_q == PH_CMD) ? {3'b000, cmd_q[7]} : out_q[31:28];
  assign io_oe    = (ph_q == PH_CMD) ? 4'b0001 :
                    (ph_q == PH_ADDR || ph_q == PH_ALT) ? 4'b1111 : 4'b0000;
endmodule

// File: rtl/qmap_ctrl.sv
module qmap_ctrl
  import qmap_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TO_CYC     = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_on,
  input  logic               map_off,
  input  logic               bus_req,
  input  logic [FADDR_W-3:0] bus_waddr,
  output logic [31:0]        bus_rdata,
  output logic               bus_ready,
  output logic               mapped,
  input  logic               seq_idle,
  output logic               seq_start,
  output logic               seq_cmd,
  output logic [FADDR_W-1:0] seq_addr,
  output logic [7:0]         seq_alt,
  output logic               seq_one,
  output logic               seq_abort,
  input  logic               byte_vld,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
  input  logic [31:0]        fifo_word,
  output logic               fifo_push,
  output logic               fifo_pop,
  output logic               fifo_flush
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int TW = $clog2(TO_CYC + 2);

  ms_t                ms_q, ms_d;
  logic               need_q, need_d;
  logic [FADDR_W-1:0] head_q, head_d;
  logic               rdy_q, rdy_d;
  logic [31:0]        data_q, data_d;
  logic [TW-1:0]      to_q, to_d;
  logic               to_exp;
  logic [FADDR_W-1:0] req_a;

  assign req_a = {bus_waddr, 2'b00};

  if (TO_CYC > 0) begin : g_to
    assign to_exp = (to_q == TW'(TO_CYC - 1));
  end else begin : g_no_to
    assign to_exp = 1'b0;
  end

  always_comb begin
    ms_d = ms_q; need_d = need_q; head_d = head_q; rdy_d = 1'b0;
    data_d = data_q; to_d = to_q;
    seq_start = 1'b0; seq_cmd = 1'b0; seq_addr = req_a; seq_alt = ALT_HOLD;
    seq_one = 1'b0; seq_abort = 1'b0; fifo_pop = 1'b0; fifo_flush = 1'b0;
    unique case (ms_q)
      MS_OFF: begin
        if (map_on) begin
          ms_d   = MS_READY;
          need_d = 1'b1;
        end
      end
      MS_READY: begin
        if (map_off) begin
          ms_d = MS_LEAVE;
        end else if (bus_req && !rdy_q && seq_idle) begin
          seq_start = 1'b1;
          seq_cmd   = need_q;
          need_d    = 1'b0;
          head_d    = req_a;
          to_d      = '0;
          ms_d      = MS_OPEN;
        end
      end
      MS_OPEN: begin
        if (map_off) begin
          seq_abort  = 1'b1;
          fifo_flush = 1'b1;
          ms_d       = MS_LEAVE;
        end else if (bus_req && !rdy_q) begin
          to_d = '0;
          if (req_a == head_q) begin
            if (fifo_cnt >= CW'(4)) begin
              fifo_pop = 1'b1;
              rdy_d    = 1'b1;
              data_d   = fifo_word;
              head_d   = head_q + FADDR_W'(4);
            end
          end else begin
            seq_abort  = 1'b1;
            fifo_flush = 1'b1;
            ms_d       = MS_READY;
          end
        end else if (to_exp) begin
          seq_abort  = 1'b1;
          fifo_flush = 1'b1;
          ms_d       = MS_READY;
        end else begin
          to_d = to_q + TW'(1);
        end
      end
      MS_LEAVE: begin
        if (seq_idle) begin
          seq_start = 1'b1;
          seq_cmd   = 1'b1;
          seq_addr  = '0;
          seq_alt   = ALT_LEAVE;
          seq_one   = 1'b1;
          ms_d      = MS_FINAL;
        end
      end
      MS_FINAL: begin
        if (seq_idle) begin
          ms_d   = MS_OFF;
          need_d = 1'b1;
        end
      end
      default: ms_d = MS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q <= MS_OFF; need_q <= 1'b1; head_q <= '0; rdy_q <= 1'b0;
      data_q <= '0; to_q <= '0;
    end else begin
      ms_q <= ms_d; need_q <= need_d; head_q <= head_d; rdy_q <= rdy_d;
      data_q <= data_d; to_q <= to_d;
    end
  end

  assign fifo_push = byte_vld && (ms_q == MS_OPEN) && !fifo_flush;
  assign bus_rdata = data_q;
  assign bus_ready = rdy_q;
  assign mapped    = (ms_q == MS_READY) || (ms_q == MS_OPEN);
endmodule

// File: rtl/qmap_reader.sv
module qmap_reader
  import qmap_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CSH_CYC    = 3,
  parameter int TO_CYC     = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        map_on,
  input  logic        map_off,
  input  logic        bus_req,
  input  logic [21:0] bus_waddr,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  output logic        mapped,
  output logic        busy,
  output logic        fl_sclk,
  output logic        fl_cs_n,
  output logic [3:0]  fl_io_o,
  output logic [3:0]  fl_io_oe,
  input  logic [3:0]  fl_io_i
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic               seq_idle, seq_start, seq_cmd, seq_one, seq_abort;
  logic [FADDR_W-1:0] seq_addr;
  logic [7:0]         seq_alt, byte_out;
  logic               byte_vld, fifo_push, fifo_pop, fifo_flush, fifo_full;
  logic [CW-1:0]      fifo_cnt;
  logic [31:0]        fifo_word;

  qmap_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .TO_CYC(TO_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .map_on(map_on), .map_off(map_off),
    .bus_req(bus_req), .bus_waddr(bus_waddr), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .mapped(mapped), .seq_idle(seq_idle),
    .seq_start(seq_start), .seq_cmd(seq_cmd), .seq_addr(seq_addr),
    .seq_alt(seq_alt), .seq_one(seq_one), .seq_abort(seq_abort),
    .byte_vld(byte_vld), .fifo_cnt(fifo_cnt), .fifo_word(fifo_word),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush)
  );

  qmap_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i), .flush(fifo_flush), .push(fifo_push),
    .push_byte(byte_out), .pop4(fifo_pop), .word(fifo_word),
    .count(fifo_cnt), .full(fifo_full)
  );

  qmap_serial #(.CSH_CYC(CSH_CYC)) u_ser (
    .clk(clk), .rst_n(rst_i), .start(seq_start), .start_cmd(seq_cmd),
    .start_addr(seq_addr), .start_alt(seq_alt), .start_one(seq_one),
    .abort(seq_abort), .hold(fifo_full), .idle(seq_idle),
    .byte_vld(byte_vld), .byte_out(byte_out), .sclk(fl_sclk),
    .cs_n(fl_cs_n), .io_o(fl_io_o), .io_oe(fl_io_oe), .io_i(fl_io_i)
  );

  assign busy = !seq_idle;
endmodule

// File: rtl/qmap_reader_chk.sv
module qmap_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_ready,
  input logic       mapped,
  input logic       busy,
  input logic       fl_sclk,
  input logic       fl_cs_n,
  input logic [3:0] fl_io_oe
);
  // R12
  cs_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_cs_n |-> busy);

  // R12
  sclk_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_sclk |-> !fl_cs_n);

  // R2
  ready_mapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> mapped);

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_cs_n) |=> fl_cs_n);

  // R1
  lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> (fl_io_oe == 4'b0000));
endmodule

bind qmap_reader qmap_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .mapped(mapped),
  .busy(busy), .fl_sclk(fl_sclk), .fl_cs_n(fl_cs_n), .fl_io_oe(fl_io_oe)
);

// File: tb/sim_qmap_reader.sv
`timescale 1ns/1ps
module sim_qmap_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_on = 1'b0, map_off = 1'b0, bus_req = 1'b0;
  logic [21:0] bus_waddr = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, mapped, busy, fl_sclk, fl_cs_n;
  logic [3:0]  fl_io_o, fl_io_oe;
  logic [3:0]  fl_io_i = 4'h0;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  qmap_reader #(.FIFO_DEPTH(8), .CSH_CYC(3), .TO_CYC(400)) u0 (
    .clk(clk), .rst_n(rst_n), .map_on(map_on), .map_off(map_off),
    .bus_req(bus_req), .bus_waddr(bus_waddr), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .mapped(mapped), .busy(busy),
    .fl_sclk(fl_sclk), .fl_cs_n(fl_cs_n), .fl_io_o(fl_io_o),
    .fl_io_oe(fl_io_oe), .fl_io_i(fl_io_i)
  );

  function automatic logic [7:0] fb(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] fw(input logic [23:0] a);
    return {fb(a + 24'd3), fb(a + 24'd2), fb(a + 24'd1), fb(a)};
  endfunction

  // flash model
  int          m_ph = 0, m_cnt = 0, m_nib = 0;
  logic [31:0] m_sr = '0;
  logic [23:0] m_addr = '0, tr_addr = '0;
  logic [7:0]  last_alt = '0;
  logic        cont = 1'b0;
  int          op_cnt = 0, cs_falls = 0, tr_bytes = 0, proto_err = 0;

  always @(negedge fl_cs_n) begin
    cs_falls++;
    m_ph = 6; m_cnt = 0; m_sr = '0; tr_bytes = 0;
  end

  always @(posedge fl_sclk) begin
    if (!fl_cs_n) begin
      if (m_ph == 6) begin
        m_ph = (fl_io_oe == 4'b0001) ? 1 : 2;
        if (m_ph == 2 && !cont) proto_err++;
        m_cnt = 0;
      end
      case (m_ph)
        1: begin
          if (fl_io_oe != 4'b0001) proto_err++;
          m_sr = {m_sr[30:0], fl_io_o[0]}; m_cnt++;
          if (m_cnt == 8) begin
            if (m_sr[7:0] != 8'hEB) proto_err++;
            op_cnt++; m_ph = 2; m_cnt = 0;
          end
        end
        2: begin
          if (fl_io_oe != 4'b1111) proto_err++;
          m_sr = {m_sr[27:0], fl_io_o}; m_cnt++;
          if (m_cnt == 6) begin
            m_addr = m_sr[23:0]; tr_addr = m_sr[23:0]; m_ph = 3; m_cnt = 0;
          end
        end
        3: begin
          if (fl_io_oe != 4'b1111) proto_err++;
          m_sr = {m_sr[27:0], fl_io_o}; m_cnt++;
          if (m_cnt == 2) begin
            last_alt = m_sr[7:0]; cont = (m_sr[5:4] == 2'b10);
            m_ph = 4; m_cnt = 0;
          end
        end
        4: begin
          if (fl_io_oe != 4'b0000) proto_err++;
          m_cnt++;
          if (m_cnt == 4) begin m_ph = 5; m_nib = 0; end
        end
        5: begin
          if (fl_io_oe != 4'b0000) proto_err++;
          if (m_nib == 1) begin m_addr = m_addr + 24'd1; tr_bytes++; end
          m_nib = 1 - m_nib;
        end
        default: ;
      endcase
    end
  end

  always @(negedge fl_sclk) begin
    if (!fl_cs_n && m_ph == 5)
      fl_io_i = (m_nib == 1) ? fb(m_addr)[3:0] : fb(m_addr)[7:4];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    bit got = 0;
    @(negedge clk);
    bus_req = 1'b1; bus_waddr = a[23:2];
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (bus_ready) begin d = bus_rdata; got = 1; end
    end
    bus_req = 1'b0;
    if (!got) begin d = 32'hDEAD_DEAD; end
  endtask

  task automatic pulse_on();
    @(negedge clk); map_on = 1'b1; @(negedge clk); map_on = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cs_n", {31'b0, fl_cs_n}, 32'd1);
    chk("R1 sclk", {31'b0, fl_sclk}, 32'd0);
    chk("R1 oe", {28'b0, fl_io_oe}, 32'd0);
    chk("R1 ready", {31'b0, bus_ready}, 32'd0);
    chk("R1 mapped", {31'b0, mapped}, 32'd0);
  endtask

  task automatic t_off_ignored();
    bit seen = 0;
    @(negedge clk); bus_req = 1'b1; bus_waddr = 22'h40;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); if (bus_ready) seen = 1;
    end
    bus_req = 1'b0;
    chk("R2 no ready while off", {31'b0, seen}, 32'd0);
    chk("R2 no flash select", cs_falls, 0);
  endtask

  task automatic t_first_and_seq();
    logic [31:0] d;
    pulse_on();
    rd(24'h000100, d);
    chk("R6 first word", d, fw(24'h000100));
    chk("R3 opcode sent once", op_cnt, 1);
    chk("R3 address", {8'b0, tr_addr}, 32'h100);
    chk("R4 mode byte", {24'b0, last_alt}, 32'hA0);
    rd(24'h000104, d);
    chk("R7 seq word 1", d, fw(24'h000104));
    rd(24'h000108, d);
    chk("R7 seq word 2", d, fw(24'h000108));
    chk("R7 single select", cs_falls, 1);
    chk("R5 no extra opcode", op_cnt, 1);
  endtask

  task automatic t_stall();
    int b0;
    repeat (100) @(negedge clk);
    b0 = tr_bytes;
    chk("R8 bytes buffered", b0, 12 + 8);
    repeat (100) @(negedge clk);
    chk("R8 no more bytes", tr_bytes, b0);
    chk("R8 sclk held low", {31'b0, fl_sclk}, 32'd0);
    chk("R8 cs held low", {31'b0, fl_cs_n}, 32'd0);
    chk("R8 busy", {31'b0, busy}, 32'd1);
  endtask

  task automatic t_miss();
    logic [31:0] d;
    rd(24'h002000, d);
    chk("R9 new word", d, fw(24'h002000));
    chk("R9 new select", cs_falls, 2);
    chk("R9 restart address", {8'b0, tr_addr}, 32'h2000);
    chk("R5 no opcode on restart", op_cnt, 1);
    rd(24'h002004, d);
    chk("R7 after restart", d, fw(24'h002004));
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    repeat (150) @(negedge clk);
    chk("R10 still open", {31'b0, fl_cs_n}, 32'd0);
    repeat (350) @(negedge clk);
    chk("R10 released", {31'b0, fl_cs_n}, 32'd1);
    chk("R10 busy low", {31'b0, busy}, 32'd0);
    rd(24'h002008, d);
    chk("R10 word after timeout", d, fw(24'h002008));
    chk("R10 new select", cs_falls, 3);
    chk("R5 no opcode after timeout", op_cnt, 1);
  endtask

  task automatic t_leave();
    logic [31:0] d;
    @(negedge clk); map_off = 1'b1; @(negedge clk); map_off = 1'b0;
    chk("R11 mapped drops", {31'b0, mapped}, 32'd0);
    repeat (300) @(negedge clk);
    chk("R11 opcode sent", op_cnt, 2);
    chk("R11 leave mode byte", {24'b0, last_alt}, 32'h5F);
    chk("R11 address zero", {8'b0, tr_addr}, 32'h0);
    chk("R11 one byte", tr_bytes, 1);
    chk("R11 continuous mode off", {31'b0, cont}, 32'd0);
    chk("R11 cs high", {31'b0, fl_cs_n}, 32'd1);
    chk("R11 busy low", {31'b0, busy}, 32'd0);
    pulse_on();
    rd(24'h000040, d);
    chk("R3 word after reenable", d, fw(24'h000040));
    chk("R3 opcode after reenable", op_cnt, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_off_ignored();
    t_first_and_seq();
    t_stall();
    t_miss();
    t_timeout();
    t_leave();
    chk("R4 protocol errors", proto_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule